// File: doc/BRIEF.md
# Serial Port Interrupt and Status Unit

This unit sits beside the transmit and receive FIFOs of a synchronous serial port and turns their fill levels and strobes into four interrupt sources: transmit service, receive service, receive timeout and receive overrun. The two service sources follow the FIFO levels directly. The timeout and overrun sources are sticky events that software removes through a write-one clear register.

Each source has a raw bit, a software mask bit and a masked bit. The masked bits are ORed into one interrupt line. A five-bit status word reports the FIFO conditions and whether the port is busy. A small register write port carries two targets: the mask register and the clear register. All outputs are registered, so they reflect the inputs one clock after they are sampled.

Top module: `sirq_unit`

## Requirements
- R1: In raw_irq and masked_irq the source order is fixed: bit 3 transmit service, bit 2 receive service, bit 1 receive timeout, bit 0 receive overrun.
- R2: Raw transmit service is 1 one clock after tx_level is at most DEPTH/2, and 0 otherwise.
- R3: Raw receive service is 1 one clock after rx_level is at least DEPTH/2, and 0 otherwise.
- R4: Raw overrun is set one clock after rx_push is high while rx_level equals DEPTH. It then stays set until it is cleared.
- R5: Raw timeout is set after 32 bit_tick pulses with rx_level non-zero and no rx_pop or rx_push. A pop or a push restarts the count. An empty receive FIFO holds the count at zero.
- R6: A write with reg_sel=1 is a clear. Data bit 1 clears timeout and data bit 0 clears overrun. Data bits 3 and 2 have no effect.
- R7: When a new timeout or overrun event occurs in the same cycle as its clear, the bit stays set.
- R8: A write with reg_sel=0 loads reg_wdata into the mask. Each masked bit is its raw bit ANDed with its mask bit, where 1 enables the source.
- R9: irq is the OR of the four masked bits.
- R10: status bit 4 is busy (line_busy or tx_level non-zero). Bit 3 is receive full, bit 2 is receive not empty, bit 1 is transmit not full and bit 0 is transmit empty.
- R11: Reset clears the mask, the sticky bits, the timeout count and every output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_level | input | LW | Transmit FIFO fill level |
| rx_level | input | LW | Receive FIFO fill level |
| rx_pop | input | 1 | Receive FIFO read strobe |
| rx_push | input | 1 | Receive FIFO write attempt strobe |
| bit_tick | input | 1 | One pulse per serial bit period |
| line_busy | input | 1 | A frame is being shifted |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Write target: 0 mask, 1 clear |
| reg_wdata | input | 4 | Write data, bit order as in R1 |
| raw_irq | output | 4 | Raw source status |
| masked_irq | output | 4 | Raw status ANDed with the mask |
| irq | output | 1 | Combined interrupt |
| status | output | 5 | FIFO and busy flags |

## Verification
The hardest case to reach is the receive timeout. It needs a long run of bit ticks with the receive FIFO not empty and no pop or push in between. It then has to be checked one tick before the deadline, exactly at it, and again after a restart. The bench holds rx_level at one and pulses bit_tick every cycle, so the deadline falls on a known cycle. It inserts a pop partway through the run and repeats the count. The same-cycle clear-versus-event race is reached by writing the clear register in the cycle of a push into a full receive FIFO.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
    localparam int NSRC    = 4;
    localparam int IDX_TX  = 3;
    localparam int IDX_RX  = 2;
    localparam int IDX_TMO = 1;
    localparam int IDX_OVR = 0;

    typedef struct packed {
        logic busy;
        logic rx_full;
        logic rx_nempty;
        logic tx_nfull;
        logic tx_empty;
    } stat_t;

    typedef enum logic {
        SEL_MASK  = 1'b0,
        SEL_CLEAR = 1'b1
    } regsel_e;
endpackage

// File: rtl/sirq_levels.sv
module sirq_levels
    import sirq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [LW-1:0] tx_level_i,
    input  logic [LW-1:0] rx_level_i,
    input  logic          line_busy_i,
    output logic          tx_raw_o,
    output logic          rx_raw_o,
    output stat_t         stat_o
);
    localparam logic [LW-1:0] HALF = LW'(DEPTH / 2);
    localparam logic [LW-1:0] FULL = LW'(DEPTH);

    typedef struct packed {
        logic  tx_raw;
        logic  rx_raw;
        stat_t stat;
    } lvl_state_t;

    lvl_state_t st_d, st_q;

    always_comb begin
        st_d                = st_q;
        st_d.tx_raw         = (tx_level_i <= HALF);
        st_d.rx_raw         = (rx_level_i >= HALF);
        st_d.stat.busy      = line_busy_i || (tx_level_i != '0);
        st_d.stat.rx_full   = (rx_level_i == FULL);
        st_d.stat.rx_nempty = (rx_level_i != '0);
        st_d.stat.tx_nfull  = (tx_level_i != FULL);
        st_d.stat.tx_empty  = (tx_level_i == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tx_raw_o = st_q.tx_raw;
    assign rx_raw_o = st_q.rx_raw;
    assign stat_o   = st_q.stat;

    // R10: an empty transmit FIFO is never reported full
    p_empty_nfull_r10: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.stat.tx_empty |-> st_q.stat.tx_nfull);
    // R3: a full receive FIFO always raises receive service one clock later
    p_rxfull_rx_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_level_i == FULL) |=> rx_raw_o);
endmodule

// File: rtl/sirq_tmo_timer.sv
module sirq_tmo_timer #(
    parameter int TMO_TICKS = 32,
    parameter int LW        = 4,
    parameter int CW        = $clog2(TMO_TICKS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [LW-1:0] rx_level_i,
    input  logic          pop_i,
    input  logic          push_i,
    input  logic          tick_i,
    output logic          evt_o
);
    localparam logic [CW-1:0] LAST = CW'(TMO_TICKS - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_state_t;

    tmr_state_t st_d, st_q;
    logic       restart;

    always_comb begin
        st_d    = st_q;
        restart = pop_i || push_i || (rx_level_i == '0);
        evt_o   = !restart && tick_i && (st_q.cnt == LAST);
        if (restart) begin
            st_d.cnt = '0;
        end else if (tick_i) begin
            st_d.cnt = (st_q.cnt == LAST) ? '0 : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R5: a pop or push means no timeout can fire in the next cycle
    p_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i || push_i) |=> !evt_o);
endmodule

// File: rtl/sirq_sticky.sv
module sirq_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    typedef struct packed {
        logic flag;
    } stk_state_t;

    stk_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.flag = set_i || (st_q.flag && !clr_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flag;

    // R7: a new event wins over a clear in the same cycle
    p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);
    // R4: a set flag holds until cleared
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_i) |=> flag_o);
    // R6: a clear without a new event drops the flag
    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_o);
endmodule

// File: rtl/sirq_unit.sv
module sirq_unit
    import sirq_pkg::*;
#(
    parameter int DEPTH     = 8,
    parameter int TMO_TICKS = 32,
    parameter int LW        = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [LW-1:0] tx_level,
    input  logic [LW-1:0] rx_level,
    input  logic          rx_pop,
    input  logic          rx_push,
    input  logic          bit_tick,
    input  logic          line_busy,
    input  logic          reg_wr,
    input  logic          reg_sel,
    input  logic [3:0]    reg_wdata,
    output logic [3:0]    raw_irq,
    output logic [3:0]    masked_irq,
    output logic          irq,
    output logic [4:0]    status
);
    localparam int              NSTICKY = 2;
    localparam logic [LW-1:0]   HALF    = LW'(DEPTH / 2);
    localparam logic [LW-1:0]   FULL    = LW'(DEPTH);

    typedef struct packed {
        logic [NSRC-1:0] mask;
    } top_state_t;

    top_state_t         st_d, st_q;
    logic               tx_raw, rx_raw, tmo_evt;
    stat_t              stat;
    logic [NSTICKY-1:0] stk_set, stk_clr, stk_flag;
    logic               clr_wr;

    sirq_levels #(.DEPTH(DEPTH), .LW(LW)) u_levels (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_level_i (tx_level),
        .rx_level_i (rx_level),
        .line_busy_i(line_busy),
        .tx_raw_o   (tx_raw),
        .rx_raw_o   (rx_raw),
        .stat_o     (stat)
    );

    sirq_tmo_timer #(.TMO_TICKS(TMO_TICKS), .LW(LW)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_level_i (rx_level),
        .pop_i      (rx_pop),
        .push_i     (rx_push),
        .tick_i     (bit_tick),
        .evt_o      (tmo_evt)
    );

    always_comb begin
        clr_wr                = reg_wr && (regsel_e'(reg_sel) == SEL_CLEAR);
        stk_set[IDX_OVR]      = rx_push && (rx_level == FULL);
        stk_set[IDX_TMO]      = tmo_evt;
        stk_clr[IDX_OVR]      = clr_wr && reg_wdata[IDX_OVR];
        stk_clr[IDX_TMO]      = clr_wr && reg_wdata[IDX_TMO];
    end

    for (genvar g = 0; g < NSTICKY; g++) begin : g_sticky
        sirq_sticky u_stk (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (stk_set[g]),
            .clr_i  (stk_clr[g]),
            .flag_o (stk_flag[g])
        );
    end

    always_comb begin
        st_d = st_q;
        if (reg_wr && (regsel_e'(reg_sel) == SEL_MASK)) st_d.mask = reg_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        raw_irq          = '0;
        raw_irq[IDX_TX]  = tx_raw;
        raw_irq[IDX_RX]  = rx_raw;
        raw_irq[IDX_TMO] = stk_flag[IDX_TMO];
        raw_irq[IDX_OVR] = stk_flag[IDX_OVR];
        masked_irq       = raw_irq & st_q.mask;
        irq              = |masked_irq;
        status           = stat;
    end

    // R8: loading an all-zero mask silences the combined line
    p_mask_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_sel && (reg_wdata == 4'b0000)) |=> !irq);
    // R2: a transmit level at or below half gives raw transmit service next cycle
    p_tx_raw_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_level <= HALF) |=> raw_irq[IDX_TX]);
    // R4: a push into a full receive FIFO flags overrun next cycle
    p_ovr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && (rx_level == FULL)) |=> raw_irq[IDX_OVR]);
endmodule

// File: tb/sirq_unit_test.sv
module sirq_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 8;
    localparam int TMO        = 32;
    localparam int LW         = $clog2(DEPTH + 1);
    localparam int HALF       = DEPTH / 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [LW-1:0] tx_level = '0;
    logic [LW-1:0] rx_level = '0;
    logic          rx_pop = 1'b0, rx_push = 1'b0, bit_tick = 1'b0, line_busy = 1'b0;
    logic          reg_wr = 1'b0, reg_sel = 1'b0;
    logic [3:0]    reg_wdata = '0;
    logic [3:0]    raw_irq, masked_irq;
    logic          irq;
    logic [4:0]    status;

    sirq_unit #(.DEPTH(DEPTH), .TMO_TICKS(TMO)) uut (
        .clk(clk), .rst_n(rst_n), .tx_level(tx_level), .rx_level(rx_level),
        .rx_pop(rx_pop), .rx_push(rx_push), .bit_tick(bit_tick), .line_busy(line_busy),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .raw_irq(raw_irq), .masked_irq(masked_irq), .irq(irq), .status(status)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    typedef struct {
        int          due;
        string       req;
        logic [13:0] vec;
    } exp_t;

    exp_t        sbq[$];
    int          cycle = 0;
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          finished = 1'b0;
    int          m_cnt = 0;
    logic        m_tmo = 1'b0, m_ovr = 1'b0;
    logic [3:0]  m_mask = '0;

    always @(posedge clk) cycle <= cycle + 1;

    // monitor: pops the expectation that is due this cycle and compares
    initial begin
        forever begin
            @(negedge clk);
            if (sbq.size() > 0 && sbq[0].due == cycle) begin
                exp_t e;
                logic [13:0] got;
                e   = sbq.pop_front();
                got = {status, raw_irq, masked_irq, irq};
                n_cmp++;
                if (got !== e.vec) begin
                    n_bad++;
                    $display("FAIL %s: got status=%b raw=%b masked=%b irq=%b, expected status=%b raw=%b masked=%b irq=%b",
                             e.req, got[13:9], got[8:5], got[4:1], got[0],
                             e.vec[13:9], e.vec[8:5], e.vec[4:1], e.vec[0]);
                end
            end
        end
    end

    // driver: applies the current inputs for one cycle and queues the expected result
    task automatic cyc(input string req);
        logic       tev, oev;
        logic [3:0] clr, raw, msk;
        logic [4:0] st;
        exp_t       e;
        tev = (rx_level != 0) && !rx_pop && !rx_push && bit_tick && (m_cnt == TMO - 1);
        if (rx_pop || rx_push || rx_level == 0) m_cnt = 0;
        else if (bit_tick) m_cnt = (m_cnt == TMO - 1) ? 0 : m_cnt + 1;
        oev = rx_push && (rx_level == LW'(DEPTH));
        clr = (reg_wr && reg_sel) ? reg_wdata : 4'b0000;
        m_tmo = tev | (m_tmo & ~clr[1]);
        m_ovr = oev | (m_ovr & ~clr[0]);
        if (reg_wr && !reg_sel) m_mask = reg_wdata;
        raw = {(tx_level <= LW'(HALF)), (rx_level >= LW'(HALF)), m_tmo, m_ovr};
        msk = raw & m_mask;
        st  = {line_busy || (tx_level != 0), rx_level == LW'(DEPTH), rx_level != 0,
               tx_level != LW'(DEPTH), tx_level == 0};
        e.due = cycle + 1;
        e.req = req;
        e.vec = {st, raw, msk, |msk};
        sbq.push_back(e);
        @(negedge clk);
        rx_pop = 1'b0; rx_push = 1'b0; bit_tick = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic wr(input logic sel, input logic [3:0] d, input string req);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        cyc(req);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        finished = 1'b1;
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: run did not end, expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: everything zero while reset is held
        n_cmp++;
        if ({status, raw_irq, masked_irq, irq} !== 14'b0) begin
            n_bad++;
            $display("FAIL R11: got %b expected %b", {status, raw_irq, masked_irq, irq}, 14'b0);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R2 / R10: transmit side levels
        tx_level = 0; cyc("R2 tx empty");
        tx_level = 5; cyc("R2 above half");
        tx_level = 4; cyc("R2 at half");
        tx_level = 8; cyc("R10 tx full");
        tx_level = 0; line_busy = 1'b1; cyc("R10 busy from line");
        line_busy = 1'b0; cyc("R10 idle");

        // R3: receive side levels
        rx_level = 3; cyc("R3 below half");
        rx_level = 4; cyc("R3 at half");
        rx_level = 8; cyc("R3 full");

        // R8 / R9: mask and combined line
        wr(1'b0, 4'b1000, "R8 mask tx only");
        cyc("R9 combined on");
        wr(1'b0, 4'b0001, "R8 mask ovr only");
        cyc("R9 combined off");

        // R4 / R1: overrun at bit 0
        rx_push = 1'b1; cyc("R4 push into full");
        cyc("R1 overrun at bit 0");
        rx_level = 7; cyc("R4 holds");
        wr(1'b1, 4'b1100, "R6 upper clear bits ignored");
        cyc("R6 still set");
        wr(1'b1, 4'b0001, "R6 clear overrun");
        rx_push = 1'b1; cyc("R4 push below full no overrun");

        // R7: event beats clear in the same cycle
        rx_level = 8;
        rx_push = 1'b1; reg_wr = 1'b1; reg_sel = 1'b1; reg_wdata = 4'b0001;
        cyc("R7 set wins over clear");
        cyc("R7 still set");
        wr(1'b1, 4'b0001, "R6 clear again");

        // R5: receive timeout
        wr(1'b0, 4'b1111, "R8 all enabled");
        rx_level = 1; tx_level = 6; cyc("R5 start");
        for (int i = 0; i < 20; i++) begin bit_tick = 1'b1; cyc("R5 counting"); end
        rx_pop = 1'b1; cyc("R5 pop restarts");
        for (int i = 0; i < 31; i++) begin bit_tick = 1'b1; cyc("R5 before deadline"); end
        bit_tick = 1'b1; cyc("R5 deadline");
        cyc("R5 sticky");
        wr(1'b1, 4'b0010, "R6 clear timeout");
        rx_level = 0;
        for (int i = 0; i < 40; i++) begin bit_tick = 1'b1; cyc("R5 empty holds"); end
        rx_level = 2;
        for (int i = 0; i < 10; i++) begin bit_tick = 1'b1; cyc("R5 partial"); end
        rx_push = 1'b1; cyc("R5 push restarts");
        for (int i = 0; i < 32; i++) begin bit_tick = 1'b1; cyc("R5 second deadline"); end
        cyc("R9 timeout drives irq");

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule